// File: doc/BRIEF.md
# Self-Reconfiguring Multiplexer Cell Array

This block is a row of small reconfigurable cells. Each cell is a 2:1 multiplexer whose else input comes from a one-bit state register, and that register takes the cell output at every clock edge. Because of this feedback, the stored bit chooses the cell's gate kind. A stored 0 makes the cell an AND gate. A stored 1 makes it an implication gate. The same two operand wires that carry data also rewrite the stored bit, so the gate kind can change with no separate configuration wiring.

In run mode a sequencer alternates two cycle kinds. In a program cycle, every cell receives x=1 and y equal to its bit from the configuration word of the selected circuit. In a compute cycle, the primary inputs pass through a fixed chain of cells, and the last output of the chain is registered as the result. Several configuration words are held in a parameter store, so different Boolean functions share the same cells. A read mode drives every operand to zero, which presents the stored bits on the cell outputs without changing them. A direct mode lets the operands of each cell be driven from outside.

Top module: `morph_ite_array`

## Requirements
- R1: Each cell outputs `cell_out[i] = x ? y : m`, where m is its stored bit. At every clock edge outside reset, m takes that output. In direct mode (`mode`=2'b10), x and y are `dir_x[i]` and `dir_y[i]`.
- R2: A cell whose stored bit is 0 outputs x AND y. A cell whose stored bit is 1 outputs (NOT x) OR y.
- R3: A cell with stored bit 0 changes to 1 only when x=1 and y=1. A cell with stored bit 1 changes to 0 only when x=1 and y=0. Every other operand pair keeps the stored bit.
- R4: In read mode (`mode[0]`=1), every cell receives x=0 and y=0. `cell_out` then equals the stored bits, and those bits stay the same from cycle to cycle.
- R5: Driving x=1 and y=b into a cell leaves b as its stored bit, whatever the cell held before.
- R6: The first cycle spent in run mode (`mode`=2'b00) after reset, or after any other mode, is a program cycle. Program and compute cycles then alternate.
- R7: In a program cycle, cell i receives x=1 and y=`CFG_INIT[w*NCELL+i]`, where w is the value of `circ_sel` sampled in that cycle. Bit value 0 selects AND and bit value 1 selects implication. With the default parameters the words for w=0..3 are 4'h0, 4'hF, 4'h5 and 4'hA. A value on `circ_sel` during a compute cycle has no effect.
- R8: In a compute cycle, the cells form a chain. Cell 0 takes x=`pin[0]` and y=`pin[1]`. Cell i takes x equal to the output of cell i-1 and y=`pin[i+1]`. In the cycle after the compute cycle, `result_valid` is 1, `result` holds the output of the last cell, and `result_sel` holds the sampled select value. Outside that cycle, `result_valid` is 0.
- R9: A synchronous reset clears every stored bit to 0 (AND), and clears `result`, `result_valid` and `result_sel`.
- R10: Starting from a cleared cell, the operand sequence x=1,1,0,1 with y=0,1,0,1 gives the outputs 0,1,1,1 and leaves a stored 1.
- R11: The value on `pin` during a program cycle does not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | 2'b00 run, 2'b10 direct, 2'bx1 read |
| circ_sel | input | SEL_W | Stored-circuit select, sampled in program cycles |
| pin | input | NCELL+1 | Primary inputs of the cell chain |
| dir_x | input | NCELL | Direct-mode x operand, one bit per cell |
| dir_y | input | NCELL | Direct-mode y operand, one bit per cell |
| cell_out | output | NCELL | Combinational cell outputs |
| result | output | 1 | Registered output of the chain |
| result_valid | output | 1 | High for one cycle after each compute cycle |
| result_sel | output | SEL_W | Circuit select that produced `result` |

## Verification
`cell_out` is combinational, so its value is due in the same cycle the operands are applied. The stored bits that an operand pair leaves behind become visible one cycle later, once a read-mode cycle puts them on `cell_out`. A chain result is due one cycle after its compute cycle: `result_valid` rises together with the next program cycle. The driver pushes each expected result into a queue during the compute cycle, and a monitor pops the queue only when it sees `result_valid`. All outputs are sampled on the falling clock edge, after the registers have settled.

// File: rtl/morph_pkg.sv
package morph_pkg;

  localparam logic [1:0] MODE_RUN    = 2'b00;
  localparam logic [1:0] MODE_DIRECT = 2'b10;

  // multiplexer with the held bit on the else leg
  function automatic logic cell_eval(input logic x, input logic y, input logic m);
    return x ? y : m;
  endfunction

  // word w of a packed configuration store
  function automatic logic [63:0] word_slice(input logic [1023:0] store, input int w, input int ncell);
    logic [63:0] v;
    v = '0;
    for (int b = 0; b < 64; b++)
      if (b < ncell) v[b] = store[w*ncell + b];
    return v;
  endfunction

endpackage

// File: rtl/morph_cell.sv
module morph_cell (
  input  logic clk,
  input  logic rst,
  input  logic op_x,
  input  logic op_y,
  output logic out_r,
  output logic held_m
);
  import morph_pkg::*;

  assign out_r = cell_eval(op_x, op_y, held_m);

  always_ff @(posedge clk) begin
    if (rst) held_m <= 1'b0;
    else     held_m <= out_r;
  end
endmodule

// File: rtl/morph_cfg_store.sv
module morph_cfg_store #(
  parameter int NCELL = 4,
  parameter int NWORD = 4,
  parameter int SEL_W = 2,
  parameter logic [NCELL*NWORD-1:0] CFG_INIT = '0
) (
  input  logic [SEL_W-1:0] sel,
  output logic [NCELL-1:0] word
);
  logic [NCELL-1:0] words [NWORD];

  for (genvar w = 0; w < NWORD; w++) begin : g_word
    assign words[w] = CFG_INIT[w*NCELL +: NCELL];
  end

  always_comb begin
    word = '0;
    for (int w = 0; w < NWORD; w++)
      if (int'(sel) == w) word = words[w];
  end
endmodule

// File: rtl/morph_seq.sv
module morph_seq #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic [SEL_W-1:0] circ_sel,
  input  logic             chain_out,
  output logic             prog_cyc,
  output logic             cmp_cyc,
  output logic             rd_cyc,
  output logic             dir_cyc,
  output logic             result,
  output logic             result_valid,
  output logic [SEL_W-1:0] result_sel
);
  import morph_pkg::*;

  logic             phase_q;
  logic [SEL_W-1:0] act_sel_q;
  logic             run_m;

  assign run_m    = (mode == MODE_RUN);
  assign rd_cyc   = mode[0];
  assign dir_cyc  = (mode == MODE_DIRECT);
  assign prog_cyc = run_m & ~phase_q;
  assign cmp_cyc  = run_m &  phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q      <= 1'b0;
      act_sel_q    <= '0;
      result       <= 1'b0;
      result_valid <= 1'b0;
      result_sel   <= '0;
    end else begin
      phase_q      <= run_m ? ~phase_q : 1'b0;
      result_valid <= cmp_cyc;
      if (prog_cyc) act_sel_q <= circ_sel;
      if (cmp_cyc) begin
        result     <= chain_out;
        result_sel <= act_sel_q;
      end
    end
  end
endmodule

// File: rtl/morph_ite_array.sv
module morph_ite_array #(
  parameter int NCELL = 4,
  parameter int NWORD = 4,
  parameter logic [NCELL*NWORD-1:0] CFG_INIT = 16'hA5F0,
  localparam int SEL_W = (NWORD > 1) ? $clog2(NWORD) : 1,
  localparam int NPIN  = NCELL + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic [SEL_W-1:0] circ_sel,
  input  logic [NPIN-1:0]  pin,
  input  logic [NCELL-1:0] dir_x,
  input  logic [NCELL-1:0] dir_y,
  output logic [NCELL-1:0] cell_out,
  output logic             result,
  output logic             result_valid,
  output logic [SEL_W-1:0] result_sel
);
  // events brought out for the checker
  logic             prog_cyc, cmp_cyc, rd_cyc, dir_cyc;
  logic [NCELL-1:0] cfg_word;
  logic [NCELL-1:0] cell_state;
  logic             chain_out;
  logic             op_x [NCELL];
  logic             op_y [NCELL];
  logic             r_arr [NCELL];

  morph_cfg_store #(
    .NCELL(NCELL), .NWORD(NWORD), .SEL_W(SEL_W), .CFG_INIT(CFG_INIT)
  ) store_i (
    .sel  (circ_sel),
    .word (cfg_word)
  );

  morph_seq #(.SEL_W(SEL_W)) seq_i (
    .clk          (clk),
    .rst          (rst),
    .mode         (mode),
    .circ_sel     (circ_sel),
    .chain_out    (chain_out),
    .prog_cyc     (prog_cyc),
    .cmp_cyc      (cmp_cyc),
    .rd_cyc       (rd_cyc),
    .dir_cyc      (dir_cyc),
    .result       (result),
    .result_valid (result_valid),
    .result_sel   (result_sel)
  );

  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    logic link_x;
    if (i == 0) begin : g_head
      assign link_x = pin[0];
    end else begin : g_tail
      assign link_x = r_arr[i-1];
    end

    always_comb begin
      op_x[i] = 1'b0;
      op_y[i] = 1'b0;
      if (prog_cyc) begin
        op_x[i] = 1'b1;
        op_y[i] = cfg_word[i];
      end else if (cmp_cyc) begin
        op_x[i] = link_x;
        op_y[i] = pin[i+1];
      end else if (dir_cyc) begin
        op_x[i] = dir_x[i];
        op_y[i] = dir_y[i];
      end
    end

    morph_cell cell_i (
      .clk    (clk),
      .rst    (rst),
      .op_x   (op_x[i]),
      .op_y   (op_y[i]),
      .out_r  (r_arr[i]),
      .held_m (cell_state[i])
    );

    assign cell_out[i] = r_arr[i];
  end

  assign chain_out = r_arr[NCELL-1];
endmodule

// File: rtl/morph_ite_array_chk.sv
module morph_ite_array_chk #(
  parameter int NCELL = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             prog_cyc,
  input logic             cmp_cyc,
  input logic             rd_cyc,
  input logic [NCELL-1:0] cfg_word,
  input logic [NCELL-1:0] cell_state,
  input logic [NCELL-1:0] cell_out,
  input logic             result_valid
);
  // R1
  writeback_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cell_state == $past(cell_out));

  // R7
  prog_load_chk: assert property (@(posedge clk) disable iff (rst)
    prog_cyc |=> cell_state == $past(cfg_word));

  // R4
  read_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rd_cyc |=> $stable(cell_state));

  // R4
  read_out_chk: assert property (@(posedge clk) disable iff (rst)
    rd_cyc |-> cell_out == cell_state);

  // R8
  valid_after_cmp_chk: assert property (@(posedge clk) disable iff (rst)
    result_valid |-> $past(cmp_cyc));

  // R6
  cmp_after_prog_chk: assert property (@(posedge clk) disable iff (rst)
    cmp_cyc |-> $past(prog_cyc));
endmodule

bind morph_ite_array morph_ite_array_chk #(.NCELL(NCELL)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .prog_cyc     (prog_cyc),
  .cmp_cyc      (cmp_cyc),
  .rd_cyc       (rd_cyc),
  .cfg_word     (cfg_word),
  .cell_state   (cell_state),
  .cell_out     (cell_out),
  .result_valid (result_valid)
);

// File: tb/morph_ite_array_tb_top.sv
module morph_ite_array_tb_top;
  localparam int NC = 4;
  localparam logic [15:0] CFG = 16'hA5F0;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    mode = 2'b01;
  logic [1:0]    circ_sel = '0;
  logic [NC:0]   pin = '0;
  logic [NC-1:0] dir_x = '0, dir_y = '0;
  logic [NC-1:0] cell_out;
  logic          result, result_valid;
  logic [1:0]    result_sel;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  logic [2:0] exp_q [$];
  logic [NC-1:0] last_r;

  always #2 clk = ~clk; // 4 ns period

  morph_ite_array dut_i (
    .clk(clk), .rst(rst), .mode(mode), .circ_sel(circ_sel), .pin(pin),
    .dir_x(dir_x), .dir_y(dir_y), .cell_out(cell_out), .result(result),
    .result_valid(result_valid), .result_sel(result_sel)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // chain model written gate by gate
  function automatic logic [NC-1:0] chain_model(input logic [NC-1:0] w, input logic [NC:0] p);
    logic a;
    logic [NC-1:0] r;
    a = p[0];
    for (int i = 0; i < NC; i++) begin
      if (w[i]) r[i] = !a || p[i+1];
      else      r[i] = a && p[i+1];
      a = r[i];
    end
    return r;
  endfunction

  function automatic logic [NC-1:0] cfg_of(input int s);
    return CFG[s*NC +: NC];
  endfunction

  // monitor: pops one expected item per valid result
  always @(negedge clk) begin
    if (!rst && !done && result_valid) begin
      if (exp_q.size() == 0) begin
        chk("R8 unexpected valid", 32'd1, 32'd0);
      end else begin
        logic [2:0] e;
        e = exp_q.pop_front();
        chk("R8 result", {31'd0, result}, {31'd0, e[2]});
        chk("R8 result_sel", {30'd0, result_sel}, {30'd0, e[1:0]});
      end
    end
  end

  // driver: one program cycle then one compute cycle
  task automatic run_circ(input int s, input logic [NC:0] p);
    @(negedge clk);
    mode = 2'b00; circ_sel = 2'(s); pin = ~p;          // R11 junk on pin
    @(negedge clk);
    circ_sel = 2'(s + 1); pin = p;                    // R7 select ignored now
    last_r = chain_model(cfg_of(s), p);
    exp_q.push_back({last_r[NC-1], 2'(s)});
  endtask

  task automatic go_read(input string req, input logic [NC-1:0] exp);
    @(negedge clk);
    mode = 2'b01;
    #1 chk(req, {28'd0, cell_out}, {28'd0, exp});
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000 && !done) begin
      done = 1;
      chk("R6 watchdog", cyc, 5000);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [1:0] xs [4];
    logic [1:0] ys [4];
    logic [1:0] os [4];
    xs = '{2'b01, 2'b01, 2'b00, 2'b01};
    ys = '{2'b00, 2'b01, 2'b00, 2'b01};
    os = '{2'b00, 2'b01, 2'b01, 2'b01};

    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R9 result_valid", {31'd0, result_valid}, 0);
    chk("R9 result", {31'd0, result}, 0);
    chk("R9 cleared cells", {28'd0, cell_out}, 0);

    // R10 single-cell sequence on cell 0
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      mode = 2'b10; dir_x = {3'b000, xs[k][0]}; dir_y = {3'b000, ys[k][0]};
      #1 chk("R10 sequence out", {31'd0, cell_out[0]}, {31'd0, os[k][0]});
    end
    go_read("R10 end state", 4'b0001);

    // R2 R3 R5 over all operand pairs, per held value
    for (int mv = 0; mv < 2; mv++) begin
      logic [NC-1:0] exp_o, exp_m;
      @(negedge clk);
      mode = 2'b10; dir_x = 4'hF; dir_y = {NC{mv[0]}};
      go_read("R5 write", {NC{mv[0]}});
      @(negedge clk);
      mode = 2'b10; dir_x = 4'b1100; dir_y = 4'b1010;
      for (int i = 0; i < NC; i++) begin
        exp_o[i] = (mv == 0) ? (dir_x[i] & dir_y[i]) : (~dir_x[i] | dir_y[i]);
        if (mv == 0) exp_m[i] = dir_x[i] && dir_y[i];
        else         exp_m[i] = !(dir_x[i] && !dir_y[i]);
      end
      #1 chk("R2 gate kind", {28'd0, cell_out}, {28'd0, exp_o});
      chk("R1 mux output", {28'd0, cell_out},
          {28'd0, (dir_x & dir_y) | (~dir_x & {NC{mv[0]}})});
      go_read("R3 mode change", exp_m);
      @(negedge clk);
      #1 chk("R4 read stable", {28'd0, cell_out}, {28'd0, exp_m});
    end

    // R7 R8 R11 chain results for every stored circuit
    for (int s = 0; s < 4; s++)
      for (int k = 0; k < 6; k++)
        run_circ(s, 5'((k * 7 + 3 + s) & 5'h1F));
    go_read("R8 cells hold compute outputs", last_r);

    // R6 R7 leaving run after a program cycle restarts with a program cycle
    @(negedge clk);
    mode = 2'b00; circ_sel = 2'd2;
    go_read("R7 loaded word", cfg_of(2));
    run_circ(3, 5'h16);
    run_circ(1, 5'h09);
    go_read("R8 cells after restart", last_r);

    repeat (3) @(negedge clk);
    chk("R8 all results seen", exp_q.size(), 0);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule